// File: doc/BRIEF.md
# Fractional clock divider with per-edge timing correction

The block turns a fast clock into a slower square wave whose mean frequency is a fixed rational fraction of the input. With the default parameters the ratio is 125/1944, which yields 10 MHz from 155.52 MHz. A phase accumulator gains `INC` on every enabled clock and is reduced modulo `ACC_MOD`. Each output edge lands on the first input clock edge at or after the point where the ideal edge would fall. Edges therefore arrive up to one input period late.

That lateness is deterministic. For every emitted edge the block reports how late the edge is, in units of 1/`INC` of an input clock period. A downstream phase measurement can remove this systematic error exactly.

A separate strobe marks the step on which the accumulator returns to zero. This is the boundary of the full pattern: `ACC_MOD` enabled clocks, 80 kHz at the default rates. Clearing the enable freezes the pattern in place.

Top module: `frac_edge_div`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, div_clk_o, edge_o, edge_rise_o and cycle_start_o are 0 and edge_ofs_o is 0. The accumulator starts from zero: after n enabled clocks the phase is p = INC·n.
- R2: A rising edge is reported (edge_o=1, edge_rise_o=1) on the cycle after the enabled clock for which p mod ACC_MOD < INC, with p > 0.
- R3: For a rising edge, edge_ofs_o equals p mod ACC_MOD. This is the lateness in units of 1/INC input period, and it always lies in [0, INC).
- R4: A falling edge is reported (edge_o=1, edge_rise_o=0) on the cycle after the enabled clock for which (p + ACC_MOD/2) mod ACC_MOD < INC. Its edge_ofs_o equals that residue.
- R5: div_clk_o goes to 1 with every rising edge report and to 0 with every falling edge report. It holds its value on every other cycle.
- R6: Every ACC_MOD consecutive enabled clocks counted from reset produce exactly INC rising reports and INC falling reports.
- R7: cycle_start_o pulses with the rising report for which p mod ACC_MOD = 0. It therefore always has edge_ofs_o = 0 and occurs once per ACC_MOD enabled clocks.
- R8: A clock with en_i = 0 leaves the phase unchanged and yields edge_o = 0 and cycle_start_o = 0 on the next cycle. div_clk_o keeps its value.
- R9: On any cycle with edge_o = 0, edge_rise_o and edge_ofs_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance the accumulator on this clock |
| div_clk_o | output | 1 | Divided square wave, registered |
| edge_o | output | 1 | One-cycle strobe for each divided-clock edge |
| edge_rise_o | output | 1 | 1 for a rising edge, 0 for a falling edge |
| edge_ofs_o | output | $clog2(INC) | Lateness of the edge in 1/INC input periods |
| cycle_start_o | output | 1 | Pulses when the pattern restarts at phase zero |

## Verification
Every output is one register away from the accumulator. The result of an enabled or idle clock therefore appears exactly one cycle later. The bench drives en_i on the falling edge and samples all outputs on the following falling edge, so the single rising edge in between has been applied. Expected values come from the running enabled-clock count n, taken as an absolute phase INC·n, with separate tallies for rising and falling reports over each ACC_MOD-step window. A reset in the middle of the run restarts the count, and the first edges after it are checked against a phase of zero.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_RISE = 2'd1,
    EV_FALL = 2'd2
  } edge_kind_e;
endpackage

// File: rtl/fnd_phase_acc.sv
module fnd_phase_acc #(
  parameter int ACC_MOD = 1944,
  parameter int INC     = 125,
  localparam int AW     = $clog2(ACC_MOD),
  localparam int SW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [AW-1:0] acc_o,
  output logic [SW-1:0] sum_o,
  output logic          wrap_o
);
  localparam logic [SW-1:0] MOD_S = SW'(ACC_MOD);
  localparam logic [SW-1:0] INC_S = SW'(INC);

  logic [AW-1:0] acc_q, acc_d;

  always_comb begin
    sum_o  = {1'b0, acc_q} + INC_S;
    wrap_o = sum_o >= MOD_S;
    acc_d  = wrap_o ? AW'(sum_o - MOD_S) : AW'(sum_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/fnd_edge_sel.sv
module fnd_edge_sel
  import fnd_pkg::*;
#(
  parameter int ACC_MOD = 1944,
  parameter int INC     = 125,
  localparam int AW     = $clog2(ACC_MOD),
  localparam int SW     = AW + 1,
  localparam int OW     = $clog2(INC)
) (
  input  logic [AW-1:0] acc_i,
  input  logic [SW-1:0] sum_i,
  input  logic          wrap_i,
  output edge_kind_e    kind_o,
  output logic [OW-1:0] ofs_o,
  output logic          zero_o
);
  localparam int HALF = ACC_MOD / 2;
  localparam logic [SW-1:0] MOD_S  = SW'(ACC_MOD);
  localparam logic [SW-1:0] HALF_S = SW'(HALF);
  localparam logic [AW-1:0] HALF_A = AW'(HALF);

  logic          fall;
  logic [SW-1:0] res;

  // INC < HALF, so a wrap and a half crossing never share a step
  always_comb begin
    fall   = (acc_i < HALF_A) && (sum_i >= HALF_S);
    res    = '0;
    kind_o = EV_NONE;
    if (wrap_i) begin
      kind_o = EV_RISE;
      res    = sum_i - MOD_S;
    end else if (fall) begin
      kind_o = EV_FALL;
      res    = sum_i - HALF_S;
    end
    ofs_o  = OW'(res);
    zero_o = wrap_i && (res == '0);
  end
endmodule

// File: rtl/fnd_out_reg.sv
module fnd_out_reg
  import fnd_pkg::*;
#(
  parameter int OW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  edge_kind_e    kind_i,
  input  logic [OW-1:0] ofs_i,
  input  logic          zero_i,
  output logic          div_clk_o,
  output logic          edge_o,
  output logic          edge_rise_o,
  output logic [OW-1:0] edge_ofs_o,
  output logic          cycle_start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_clk_o     <= 1'b0;
      edge_o        <= 1'b0;
      edge_rise_o   <= 1'b0;
      edge_ofs_o    <= '0;
      cycle_start_o <= 1'b0;
    end else begin
      edge_o        <= en_i && (kind_i != EV_NONE);
      edge_rise_o   <= en_i && (kind_i == EV_RISE);
      edge_ofs_o    <= (en_i && kind_i != EV_NONE) ? ofs_i : '0;
      cycle_start_o <= en_i && zero_i;
      if (en_i && kind_i == EV_RISE)      div_clk_o <= 1'b1;
      else if (en_i && kind_i == EV_FALL) div_clk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_edge_div.sv
module frac_edge_div
  import fnd_pkg::*;
#(
  parameter int ACC_MOD = 1944,
  parameter int INC     = 125,
  localparam int AW     = $clog2(ACC_MOD),
  localparam int SW     = AW + 1,
  localparam int OW     = $clog2(INC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic          div_clk_o,
  output logic          edge_o,
  output logic          edge_rise_o,
  output logic [OW-1:0] edge_ofs_o,
  output logic          cycle_start_o
);
  logic [AW-1:0] acc;
  logic [SW-1:0] sum;
  logic          wrap;
  edge_kind_e    kind;
  logic [OW-1:0] ofs;
  logic          zero;

  fnd_phase_acc #(.ACC_MOD(ACC_MOD), .INC(INC)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .acc_o  (acc),
    .sum_o  (sum),
    .wrap_o (wrap)
  );

  fnd_edge_sel #(.ACC_MOD(ACC_MOD), .INC(INC)) i_sel (
    .acc_i  (acc),
    .sum_i  (sum),
    .wrap_i (wrap),
    .kind_o (kind),
    .ofs_o  (ofs),
    .zero_o (zero)
  );

  fnd_out_reg #(.OW(OW)) i_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .kind_i        (kind),
    .ofs_i         (ofs),
    .zero_i        (zero),
    .div_clk_o     (div_clk_o),
    .edge_o        (edge_o),
    .edge_rise_o   (edge_rise_o),
    .edge_ofs_o    (edge_ofs_o),
    .cycle_start_o (cycle_start_o)
  );
endmodule

// File: rtl/frac_edge_div_chk.sv
module frac_edge_div_chk #(
  parameter int INC    = 125,
  localparam int OW    = $clog2(INC)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          div_clk_o,
  input logic          edge_o,
  input logic          edge_rise_o,
  input logic [OW-1:0] edge_ofs_o,
  input logic          cycle_start_o
);
  a_r3_ofs_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (int'(edge_ofs_o) < INC));

  a_r5_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && edge_rise_o) |-> div_clk_o);

  a_r5_fall_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && !edge_rise_o) |-> !div_clk_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_o |-> $stable(div_clk_o));

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!edge_o && !cycle_start_o));

  a_r7_cycle_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |-> (edge_o && edge_rise_o && edge_ofs_o == '0));

  a_r9_quiet_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_o |-> (!edge_rise_o && edge_ofs_o == '0));
endmodule

bind frac_edge_div frac_edge_div_chk #(.INC(INC)) i_chk (.*);

// File: tb/test_frac_edge_div.sv
module test_frac_edge_div;
  localparam int ACC_MOD = 1944;
  localparam int INC     = 125;
  localparam int HALF    = ACC_MOD / 2;
  localparam int OW      = $clog2(INC);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic          div_clk_o, edge_o, edge_rise_o, cycle_start_o;
  logic [OW-1:0] edge_ofs_o;

  int    total = 0, bad = 0;
  bit    finished = 0;
  longint n = 0;
  bit    exp_div = 0;
  int    rise_cnt = 0, fall_cnt = 0;

  always #4ns clk_i = ~clk_i;

  frac_edge_div #(.ACC_MOD(ACC_MOD), .INC(INC)) i_frac_edge_div (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pmod(input longint p, input int off);
    return int'((p + off) % ACC_MOD);
  endfunction

  // called at a falling edge; applies one clock with enable e, checks at next falling edge
  task automatic step(input bit e);
    bit er, ef, ec;
    int eo;
    en_i = e;
    @(negedge clk_i);
    er = 0; ef = 0; ec = 0; eo = 0;
    if (e) begin
      n++;
      if (pmod(INC * n, 0) < INC) begin er = 1; eo = pmod(INC * n, 0); end
      if (pmod(INC * n, HALF) < INC) begin ef = 1; eo = pmod(INC * n, HALF); end
      ec = er && (pmod(INC * n, 0) == 0);
    end
    if (er) exp_div = 1;
    if (ef) exp_div = 0;
    chk(edge_o == (er | ef), e ? "R2" : "R8", "edge_o", edge_o, er | ef);
    chk(edge_rise_o == er, ef ? "R4" : "R9", "edge_rise_o", edge_rise_o, er);
    chk(int'(edge_ofs_o) == eo, ef ? "R4" : "R3", "edge_ofs_o", edge_ofs_o, eo);
    chk(cycle_start_o == ec, "R7", "cycle_start_o", cycle_start_o, ec);
    chk(div_clk_o == exp_div, "R5", "div_clk_o", div_clk_o, exp_div);
    if (edge_o && edge_rise_o)  rise_cnt++;
    if (edge_o && !edge_rise_o) fall_cnt++;
    if (e && (n % ACC_MOD) == 0) begin
      chk(rise_cnt == INC, "R6", "rises per window", rise_cnt, INC);
      chk(fall_cnt == INC, "R6", "falls per window", fall_cnt, INC);
      rise_cnt = 0; fall_cnt = 0;
    end
  endtask

  task automatic check_reset();
    chk(div_clk_o == 0, "R1", "div_clk_o", div_clk_o, 0);
    chk(edge_o == 0, "R1", "edge_o", edge_o, 0);
    chk(edge_rise_o == 0, "R1", "edge_rise_o", edge_rise_o, 0);
    chk(edge_ofs_o == 0, "R1", "edge_ofs_o", edge_ofs_o, 0);
    chk(cycle_start_o == 0, "R1", "cycle_start_o", cycle_start_o, 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    en_i = 1'b1;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    en_i = 1'b0;
    n = 0; exp_div = 0; rise_cnt = 0; fall_cnt = 0;
    @(negedge clk_i);
    check_reset();
  endtask

  initial begin
    void'($urandom(32'h5eed));
    do_reset();
    // directed: first edges from zero phase (fall at step 8 ofs 28, rise at step 16 ofs 56)
    for (int i = 0; i < 40; i++) step(1'b1);
    // R8: long idle stretch holds phase and level
    for (int i = 0; i < 30; i++) step(1'b0);
    // random enable, about 3 of 4 clocks
    for (int i = 0; i < 6000; i++) step(($urandom % 4) != 0);
    // R1: reset mid-run, then a clean full window
    do_reset();
    for (int i = 0; i < 2 * ACC_MOD + 5; i++) step(1'b1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule